// File: doc/BRIEF.md
# Set/Clear GPIO Port with Auto-Direction

This block is a general-purpose I/O port of `NPINS` pins (32 by default) attached to a simple memory-mapped register bus. Software never performs a read-modify-write to change an output: it writes a mask to a "set" address or to a "clear" address. Only the pins whose mask bit is 1 are affected. Either write also turns those pins into driven outputs, so a single store both picks a level and claims the pin. A separate address hands masked pins back to input (tristate).

Several addresses have one meaning on read and a different one on write. The direction address reads back the output-enable vector. The set address reads back the output latch. The pin address reads the synchronized pad levels and, on write, loads the input-enable vector that gates those levels. The pad side is a data/enable pair, and the pad cell turns it into a driven or high-impedance pin.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset every output enable is 0, the output latch is 0 and the input-enable vector is 0. Reads at the direction, set and pin addresses all return 0.
- R2: A write to offset 0x108 sets the latch bit and the output-enable bit of every pin whose write-data bit is 1. The change is visible from the clock edge that takes the write.
- R3: A write to offset 0x10C clears the latch bit and sets the output-enable bit of every pin whose write-data bit is 1.
- R4: A write to offset 0x100 clears the output-enable bit of every pin whose write-data bit is 1, and leaves the latch unchanged.
- R5: In writes to offsets 0x100, 0x108 and 0x10C, a pin whose write-data bit is 0 keeps both its latch bit and its output-enable bit.
- R6: While `rd_en` is high, `rdata` returns the following in the same cycle: the output-enable vector at offset 0x100, and the output latch at offset 0x108. While `rd_en` is low, `rdata` is 0.
- R7: A read at offset 0x110 returns the pad input levels ANDed with the input-enable vector. A pad level change appears there only after two rising clock edges.
- R8: A write to offset 0x110 loads the whole input-enable vector from the write data. It changes neither the latch nor the output enables.
- R9: Reads of any other offset return 0, and writes to any other offset change no state.
- R10: Bit i of `pad_dout` is latch bit i and bit i of `pad_oe` is output-enable bit i. The pin is driven when `pad_oe[i]` is 1 and high-impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (12) | Byte offset of the access |
| wdata | input | NPINS (32) | Write data / pin mask |
| rdata | output | NPINS (32) | Read data, combinational |
| pad_in | input | NPINS (32) | Asynchronous pad input levels |
| pad_dout | output | NPINS (32) | Pad output data |
| pad_oe | output | NPINS (32) | Pad output enable, 1 = drive |

## Verification
The hardest situation to reach from the ports is a pin that holds a latch value while it is tristated. The value must come back unchanged when a later clear or set write on a different pin leaves that pin's mask bit at 0. The stimulus drives a pin high, tristates it through the direction address, and then writes masks that exclude it. Afterwards it reads both the latch and the enable vector. The synchronizer delay is checked by changing `pad_in` and reading the pin address after zero, one and two clock edges. Only the read after the second edge may show the new level.

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFS_DIR = 'h100,
  parameter logic [ADDR_W-1:0] OFS_SET = 'h108,
  parameter logic [ADDR_W-1:0] OFS_CLR = 'h10C,
  parameter logic [ADDR_W-1:0] OFS_PIN = 'h110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_dout,
  output logic [NPINS-1:0]  pad_oe
);

  logic [NPINS-1:0] lat_q, oe_q, inen_q, sync1_q, sync2_q;

  wire hit_dir = addr == OFS_DIR;
  wire hit_set = addr == OFS_SET;
  wire hit_clr = addr == OFS_CLR;
  wire hit_pin = addr == OFS_PIN;
  wire drive_w = wr_en && (hit_set || hit_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      oe_q   <= '0;
      inen_q <= '0;
    end else if (wr_en) begin
      if (hit_set) lat_q <= lat_q | wdata;
      if (hit_clr) lat_q <= lat_q & ~wdata;
      if (drive_w) oe_q <= oe_q | wdata;
      if (hit_dir) oe_q <= oe_q & ~wdata;
      if (hit_pin) inen_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    sync1_q <= pad_in;
    sync2_q <= sync1_q;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit_dir) rdata = oe_q;
      if (hit_set) rdata = lat_q;
      if (hit_pin) rdata = sync2_q & inen_q;
    end
  end

  assign pad_dout = lat_q;
  assign pad_oe   = oe_q;

  p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> (pad_oe == '0 && pad_dout == '0));

  p_set_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_SET) |=> ((pad_dout & $past(wdata)) == $past(wdata)) && ((pad_oe & $past(wdata)) == $past(wdata)));

  p_clr_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CLR) |=> ((pad_dout & $past(wdata)) == '0) && ((pad_oe & $past(wdata)) == $past(wdata)));

  p_dir_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DIR) |=> ((pad_oe & $past(wdata)) == '0) && $stable(pad_dout));

  p_unmasked_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == OFS_SET || addr == OFS_CLR || addr == OFS_DIR)) |=>
      ((pad_dout & ~$past(wdata)) == ($past(pad_dout) & ~$past(wdata))) &&
      ((pad_oe & ~$past(wdata)) == ($past(pad_oe) & ~$past(wdata))));

  p_idle_read_r6: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |-> rdata == '0);

  p_pin_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_PIN) |-> rdata == ($past(pad_in, 2) & inen_q));

  p_pin_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_PIN) |=> $stable(pad_oe) && $stable(pad_dout));

  p_undecoded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != OFS_DIR && addr != OFS_SET && addr != OFS_CLR && addr != OFS_PIN) |=>
      $stable(pad_oe) && $stable(pad_dout));

  p_oe_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pad_oe & ~$past(pad_oe))) |-> $past(wr_en) && ($past(addr) == OFS_SET || $past(addr) == OFS_CLR));

endmodule

// File: tb/sim_gpio_setclr_port.sv
module sim_gpio_setclr_port;
  localparam int N = 32;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [N-1:0] wdata = '0, pad_in = '0;
  logic [N-1:0] rdata, pad_dout, pad_oe;
  logic [N-1:0] m_lat = '0, m_oe = '0, m_inen = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_setclr_port u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_dout(pad_dout), .pad_oe(pad_oe));

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [N-1:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [N-1:0] d);
    rd_en = 1; addr = a;
    #1 d = rdata;
    rd_en = 0; addr = '0;
  endtask

  task automatic check_state(string req);
    logic [N-1:0] v;
    rd(12'h100, v); check(req, v, m_oe);
    rd(12'h108, v); check(req, v, m_lat);
    check(req, pad_oe, m_oe);
    check(req, pad_dout, m_lat);
  endtask

  task automatic t_reset;
    logic [N-1:0] v;
    check_state("R1");
    rd(12'h110, v); check("R1", v, '0);
    #1 check("R6", rdata, '0);
  endtask

  task automatic t_set;
    wr(12'h108, 32'h0000_00F1);
    m_lat |= 32'h0000_00F1; m_oe |= 32'h0000_00F1;
    check_state("R2");
    wr(12'h108, 32'h8000_0000);
    m_lat |= 32'h8000_0000; m_oe |= 32'h8000_0000;
    check_state("R2");
  endtask

  task automatic t_clear;
    wr(12'h10C, 32'h0000_0030);
    m_lat &= ~32'h0000_0030;
    check_state("R3");
    wr(12'h10C, 32'h0001_0000);
    m_oe |= 32'h0001_0000;
    check_state("R3");
  endtask

  task automatic t_tristate;
    wr(12'h100, 32'h8000_0001);
    m_oe &= ~32'h8000_0001;
    check_state("R4");
    check("R10", pad_dout & 32'h8000_0001, 32'h8000_0001);
  endtask

  task automatic t_masked;
    wr(12'h108, 32'h0000_0100); m_lat |= 32'h100; m_oe |= 32'h100;
    wr(12'h10C, 32'h0000_0200); m_oe |= 32'h200;
    wr(12'h100, 32'h0000_0100); m_oe &= ~32'h100;
    check_state("R5");
    check("R5", pad_dout[31], 1'b1);
    check("R5", pad_oe[31], 1'b0);
  endtask

  task automatic t_inen_pins;
    logic [N-1:0] v;
    pad_in = 32'hA5A5_0F0F;
    @(negedge clk); @(negedge clk);
    rd(12'h110, v); check("R8", v, '0);
    wr(12'h110, 32'hFFFF_00FF); m_inen = 32'hFFFF_00FF;
    check_state("R8");
    rd(12'h110, v); check("R8", v, 32'hA5A5_0F0F & m_inen);
    pad_in = 32'h5A5A_F0F0;
    rd(12'h110, v); check("R7", v, 32'hA5A5_0F0F & m_inen);
    @(negedge clk);
    rd(12'h110, v); check("R7", v, 32'hA5A5_0F0F & m_inen);
    @(negedge clk);
    rd(12'h110, v); check("R7", v, 32'h5A5A_F0F0 & m_inen);
  endtask

  task automatic t_undecoded;
    logic [N-1:0] v;
    wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h10D, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    check_state("R9");
    rd(12'h104, v); check("R9", v, '0);
    rd(12'h114, v); check("R9", v, '0);
    rd(12'h10C, v); check("R9", v, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_set();
    t_clear();
    t_tristate();
    t_masked();
    t_inen_pins();
    t_undecoded();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule